// File: doc/BRIEF.md
# Age-Matrix Oldest-Ready Selector

This block tracks the relative age of the entries in three groups of a scheduling queue and names, for any set of requesting entries, the one that has waited longest. The groups are called enqueue, simple and complex. Each group keeps a square bit matrix in which bit [i][j] is set when entry i is older than entry j. An entry written in a cycle becomes younger than every entry already held in its group. Each group accepts up to two writes per cycle, on two write ports. Payload storage, operand readiness and wakeup matching are handled elsewhere. The block only needs to know which slot is written in each cycle and, for each query, which slots are requesting.

Every group has several independent query ports. A query port takes a request mask and returns a one-hot grant for the oldest requesting entry of that group. Port 0 of all three groups also feeds a fixed-priority combiner that drives the first dequeue port. The combiner takes the complex group's winner if it has one, otherwise the simple group's winner, otherwise the enqueue group's winner.

The block has no back-pressure. A write on either port is accepted in the cycle it is presented. The caller chooses free slots and must keep requests limited to slots that hold live entries. Queries are combinational and reflect writes from earlier cycles only. A freed slot needs no notification, because its age is rewritten when it is next filled.

Top module: `age_select_top`

## Requirements
- R1: After reset, within each group a lower entry index is older than a higher one.
- R2: An entry written on either port becomes younger than every other entry in its group. Entries not written keep their relative order for any number of cycles.
- R3: When both write ports of a group name slots in the same cycle, the slot on port 0 is older than the slot on port 1. Each port names at most one slot, and the two ports never name the same slot.
- R4: Each query grant is one-hot for the oldest requesting entry of its group. The grant is all-zero exactly when the request mask is zero.
- R5: The query ports of a group are independent. Different masks presented in the same cycle each get their own correct grant.
- R6: A write takes effect at the next rising clock edge. A query made in the same cycle as the write still sees the previous order.
- R7: The combined pick priority is complex, then simple, then enqueue. pick_grp_o encodes 2 for complex, 1 for simple and 0 for enqueue. Only the winning group's pick vector is non-zero, and it equals that group's port 0 grant.
- R8: The combined pick uses only query port 0 of each group. pick_vld_o is 0, and all pick vectors are zero, when no port 0 request is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_e0_i | input | NE | Enqueue group, write port 0 slot (one-hot or zero) |
| enq_e1_i | input | NE | Enqueue group, write port 1 slot (one-hot or zero) |
| enq_s0_i | input | NS | Simple group, write port 0 slot |
| enq_s1_i | input | NS | Simple group, write port 1 slot |
| enq_c0_i | input | NC | Complex group, write port 0 slot |
| enq_c1_i | input | NC | Complex group, write port 1 slot |
| req_e_i | input | NQ*NE | Enqueue group request masks; port q occupies bits [q*NE +: NE] |
| req_s_i | input | NQ*NS | Simple group request masks, same layout |
| req_c_i | input | NQ*NC | Complex group request masks, same layout |
| gnt_e_o | output | NQ*NE | Enqueue group one-hot grants per query port |
| gnt_s_o | output | NQ*NS | Simple group one-hot grants per query port |
| gnt_c_o | output | NQ*NC | Complex group one-hot grants per query port |
| pick_vld_o | output | 1 | Combined pick is valid |
| pick_grp_o | output | 2 | Winning group: 0 enqueue, 1 simple, 2 complex |
| pick_e_o | output | NE | Combined pick slot when the enqueue group wins |
| pick_s_o | output | NS | Combined pick slot when the simple group wins |
| pick_c_o | output | NC | Combined pick slot when the complex group wins |

## Verification
A wrong or stale matrix bit does not show in every cycle. It appears only when a request mask contains both entries of the damaged pair, and then the grant names the younger entry. For that reason the bench sweeps every request mask of every group after each write pattern. A mistake in how writes update the matrix becomes visible in the cycle after the write, and only to queries that include the new entry together with an older one.

// File: rtl/age_sel_pkg.sv
package age_sel_pkg;
  typedef enum logic [1:0] {
    GRP_ENQ = 2'd0,
    GRP_SMP = 2'd1,
    GRP_CPX = 2'd2
  } grp_e;
endpackage

// File: rtl/age_pick.sv
module age_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0][N-1:0] older_i,
  input  logic [N-1:0]        req_i,
  output logic [N-1:0]        gnt_o
);
  for (genvar i = 0; i < N; i++) begin : g_col
    logic [N-1:0] beaten_by;
    for (genvar j = 0; j < N; j++) begin : g_row
      assign beaten_by[j] = older_i[j][i];
    end
    assign gnt_o[i] = req_i[i] & ~|(req_i & beaten_by);
  end
endmodule

// File: rtl/age_matrix.sv
module age_matrix #(
  parameter int N  = 6,
  parameter int NQ = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         enq0_i,
  input  logic [N-1:0]         enq1_i,
  input  logic [NQ-1:0][N-1:0] req_i,
  output logic [NQ-1:0][N-1:0] gnt_o
);
  logic [N-1:0][N-1:0] older_q, older_d;

  always_comb begin
    older_d = older_q;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i != j) begin
          if (enq1_i[j])      older_d[i][j] = 1'b1;
          else if (enq1_i[i]) older_d[i][j] = 1'b0;
          else if (enq0_i[j]) older_d[i][j] = 1'b1;
          else if (enq0_i[i]) older_d[i][j] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          older_q[i][j] <= (i < j);
    end else begin
      older_q <= older_d;
    end
  end

  AST_ENQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(enq0_i) && $onehot0(enq1_i)); // R3
  AST_ENQ_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (enq0_i & enq1_i) == '0); // R3

  for (genvar q = 0; q < NQ; q++) begin : g_q
    age_pick #(.N(N)) u_pick (
      .older_i(older_q),
      .req_i  (req_i[q]),
      .gnt_o  (gnt_o[q])
    );

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o[q])); // R4
    AST_GNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_i[q]) |-> (|gnt_o[q])); // R4
    AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o[q] & ~req_i[q]) == '0); // R4
    AST_YOUNG_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && |(req_i[q] & $past(enq1_i)) && |(req_i[q] & ~$past(enq1_i)))
        |-> ((gnt_o[q] & $past(enq1_i)) == '0)); // R2
  end
endmodule

// File: rtl/grp_prio.sv
module grp_prio
  import age_sel_pkg::*;
#(
  parameter int NE = 2,
  parameter int NS = 6,
  parameter int NC = 4
) (
  input  logic [NE-1:0] win_e_i,
  input  logic [NS-1:0] win_s_i,
  input  logic [NC-1:0] win_c_i,
  output logic          vld_o,
  output grp_e          grp_o,
  output logic [NE-1:0] pick_e_o,
  output logic [NS-1:0] pick_s_o,
  output logic [NC-1:0] pick_c_o
);
  logic has_e, has_s, has_c;
  assign has_e = |win_e_i;
  assign has_s = |win_s_i;
  assign has_c = |win_c_i;

  always_comb begin
    vld_o    = has_c | has_s | has_e;
    grp_o    = GRP_ENQ;
    pick_e_o = '0;
    pick_s_o = '0;
    pick_c_o = '0;
    if (has_c) begin
      grp_o    = GRP_CPX;
      pick_c_o = win_c_i;
    end else if (has_s) begin
      grp_o    = GRP_SMP;
      pick_s_o = win_s_i;
    end else begin
      pick_e_o = win_e_i;
    end
  end
endmodule

// File: rtl/age_select_top.sv
module age_select_top
  import age_sel_pkg::*;
#(
  parameter int NE = 2,
  parameter int NS = 6,
  parameter int NC = 4,
  parameter int NQ = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NE-1:0]   enq_e0_i,
  input  logic [NE-1:0]   enq_e1_i,
  input  logic [NS-1:0]   enq_s0_i,
  input  logic [NS-1:0]   enq_s1_i,
  input  logic [NC-1:0]   enq_c0_i,
  input  logic [NC-1:0]   enq_c1_i,
  input  logic [NQ*NE-1:0] req_e_i,
  input  logic [NQ*NS-1:0] req_s_i,
  input  logic [NQ*NC-1:0] req_c_i,
  output logic [NQ*NE-1:0] gnt_e_o,
  output logic [NQ*NS-1:0] gnt_s_o,
  output logic [NQ*NC-1:0] gnt_c_o,
  output logic            pick_vld_o,
  output logic [1:0]      pick_grp_o,
  output logic [NE-1:0]   pick_e_o,
  output logic [NS-1:0]   pick_s_o,
  output logic [NC-1:0]   pick_c_o
);
  logic [NQ-1:0][NE-1:0] req_e, gnt_e;
  logic [NQ-1:0][NS-1:0] req_s, gnt_s;
  logic [NQ-1:0][NC-1:0] req_c, gnt_c;
  grp_e                  grp;

  assign req_e   = req_e_i;
  assign req_s   = req_s_i;
  assign req_c   = req_c_i;
  assign gnt_e_o = gnt_e;
  assign gnt_s_o = gnt_s;
  assign gnt_c_o = gnt_c;

  age_matrix #(.N(NE), .NQ(NQ)) u_mat_e (
    .clk(clk), .rst_n(rst_n), .enq0_i(enq_e0_i), .enq1_i(enq_e1_i),
    .req_i(req_e), .gnt_o(gnt_e)
  );
  age_matrix #(.N(NS), .NQ(NQ)) u_mat_s (
    .clk(clk), .rst_n(rst_n), .enq0_i(enq_s0_i), .enq1_i(enq_s1_i),
    .req_i(req_s), .gnt_o(gnt_s)
  );
  age_matrix #(.N(NC), .NQ(NQ)) u_mat_c (
    .clk(clk), .rst_n(rst_n), .enq0_i(enq_c0_i), .enq1_i(enq_c1_i),
    .req_i(req_c), .gnt_o(gnt_c)
  );

  grp_prio #(.NE(NE), .NS(NS), .NC(NC)) u_prio (
    .win_e_i (gnt_e[0]),
    .win_s_i (gnt_s[0]),
    .win_c_i (gnt_c[0]),
    .vld_o   (pick_vld_o),
    .grp_o   (grp),
    .pick_e_o(pick_e_o),
    .pick_s_o(pick_s_o),
    .pick_c_o(pick_c_o)
  );
  assign pick_grp_o = grp;

  AST_CPX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_c[0]) |-> (pick_vld_o && pick_grp_o == 2'd2 && pick_s_o == '0 && pick_e_o == '0)); // R7
  AST_SMP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|req_c[0]) && (|req_s[0])) |-> (pick_grp_o == 2'd1 && pick_s_o == gnt_s[0] && pick_e_o == '0)); // R7
  AST_IDLE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_e[0] == '0 && req_s[0] == '0 && req_c[0] == '0) |-> !pick_vld_o); // R8
endmodule

// File: tb/age_select_top_tb_top.sv
`timescale 1ns/1ps
module age_select_top_tb_top;
  localparam int NE = 2, NS = 6, NC = 4, NQ = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NE-1:0] enq_e0 = '0, enq_e1 = '0;
  logic [NS-1:0] enq_s0 = '0, enq_s1 = '0;
  logic [NC-1:0] enq_c0 = '0, enq_c1 = '0;
  logic [NQ*NE-1:0] req_e = '0;
  logic [NQ*NS-1:0] req_s = '0;
  logic [NQ*NC-1:0] req_c = '0;
  logic [NQ*NE-1:0] gnt_e;
  logic [NQ*NS-1:0] gnt_s;
  logic [NQ*NC-1:0] gnt_c;
  logic pick_vld;
  logic [1:0] pick_grp;
  logic [NE-1:0] pick_e;
  logic [NS-1:0] pick_s;
  logic [NC-1:0] pick_c;

  always #4 clk = ~clk;

  age_select_top #(.NE(NE), .NS(NS), .NC(NC), .NQ(NQ)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .enq_e0_i(enq_e0), .enq_e1_i(enq_e1), .enq_s0_i(enq_s0), .enq_s1_i(enq_s1),
    .enq_c0_i(enq_c0), .enq_c1_i(enq_c1),
    .req_e_i(req_e), .req_s_i(req_s), .req_c_i(req_c),
    .gnt_e_o(gnt_e), .gnt_s_o(gnt_s), .gnt_c_o(gnt_c),
    .pick_vld_o(pick_vld), .pick_grp_o(pick_grp),
    .pick_e_o(pick_e), .pick_s_o(pick_s), .pick_c_o(pick_c)
  );

  int sz [3] = '{NE, NS, NC};
  int stamp [3][6];
  int cnt;
  int p0 [3];
  int p1 [3];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_req(int g, int q, int m);
    case (g)
      0: req_e[q*NE +: NE] = m[NE-1:0];
      1: req_s[q*NS +: NS] = m[NS-1:0];
      default: req_c[q*NC +: NC] = m[NC-1:0];
    endcase
  endtask

  function automatic int gnt_of(int g, int q);
    case (g)
      0: return int'(gnt_e[q*NE +: NE]);
      1: return int'(gnt_s[q*NS +: NS]);
      default: return int'(gnt_c[q*NC +: NC]);
    endcase
  endfunction

  function automatic int oldest(int g, int m);
    int best = -1;
    for (int i = 0; i < sz[g]; i++)
      if (m[i] && (best < 0 || stamp[g][i] < stamp[g][best])) best = i;
    return (best < 0) ? 0 : (1 << best);
  endfunction

  task automatic clear_reqs();
    req_e = '0; req_s = '0; req_c = '0;
  endtask

  // drive p0/p1 for one clock, then advance the stamp model
  task automatic do_cycle();
    @(negedge clk);
    enq_e0 = '0; enq_e1 = '0; enq_s0 = '0; enq_s1 = '0; enq_c0 = '0; enq_c1 = '0;
    if (p0[0] >= 0) enq_e0[p0[0]] = 1'b1;
    if (p1[0] >= 0) enq_e1[p1[0]] = 1'b1;
    if (p0[1] >= 0) enq_s0[p0[1]] = 1'b1;
    if (p1[1] >= 0) enq_s1[p1[1]] = 1'b1;
    if (p0[2] >= 0) enq_c0[p0[2]] = 1'b1;
    if (p1[2] >= 0) enq_c1[p1[2]] = 1'b1;
    @(posedge clk);
    #1;
    for (int g = 0; g < 3; g++) begin
      if (p0[g] >= 0) begin stamp[g][p0[g]] = cnt; cnt++; end
      if (p1[g] >= 0) begin stamp[g][p1[g]] = cnt; cnt++; end
    end
    enq_e0 = '0; enq_e1 = '0; enq_s0 = '0; enq_s1 = '0; enq_c0 = '0; enq_c1 = '0;
  endtask

  task automatic no_enq();
    for (int g = 0; g < 3; g++) begin p0[g] = -1; p1[g] = -1; end
  endtask

  task automatic sweep(int g);
    int full = (1 << sz[g]) - 1;
    for (int m = 0; m <= full; m++) begin
      set_req(g, 0, m);
      set_req(g, 1, ~m & full);
      #1;
      chk($sformatf("R4 g%0d mask=%0h", g, m), gnt_of(g, 0), oldest(g, m));
      chk($sformatf("R5 g%0d port1 mask=%0h", g, ~m & full), gnt_of(g, 1), oldest(g, ~m & full));
    end
    clear_reqs();
  endtask

  task automatic comb_check(int me, int ms, int mc);
    int ee, es, ec;
    set_req(0, 0, me); set_req(1, 0, ms); set_req(2, 0, mc);
    set_req(0, 1, 3); set_req(1, 1, 63); set_req(2, 1, 15);
    #1;
    ee = 0; es = 0; ec = 0;
    if (mc != 0) ec = oldest(2, mc);
    else if (ms != 0) es = oldest(1, ms);
    else ee = oldest(0, me);
    chk("R8 pick_vld", int'(pick_vld), int'((me | ms | mc) != 0));
    chk("R7 pick_grp", int'(pick_grp), (mc != 0) ? 2 : (ms != 0) ? 1 : 0);
    chk("R7 pick_c", int'(pick_c), ec);
    chk("R7 pick_s", int'(pick_s), es);
    chk("R7 pick_e", int'(pick_e), ee);
    clear_reqs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 3; g++)
      for (int i = 0; i < 6; i++) stamp[g][i] = i;
    cnt = 6;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // reset state, idle requests
    chk("R8 idle pick_vld", int'(pick_vld), 0);
    chk("R4 idle gnt_s", int'(gnt_s), 0);
    // R1: reset order, lower index oldest
    for (int g = 0; g < 3; g++) begin
      set_req(g, 0, (1 << sz[g]) - 1);
      #1;
      chk($sformatf("R1 g%0d all", g), gnt_of(g, 0), 1);
      set_req(g, 0, (1 << sz[g]) - 2);
      #1;
      chk($sformatf("R1 g%0d no0", g), gnt_of(g, 0), 2);
    end
    clear_reqs();

    // R6: same-cycle query sees the old order
    @(negedge clk);
    enq_s0 = 6'b000001;
    req_s[0 +: NS] = 6'b111111;
    #1;
    chk("R6 same cycle", int'(gnt_s[0 +: NS]), 1);
    @(posedge clk);
    #1;
    enq_s0 = '0;
    stamp[1][0] = cnt; cnt++;
    chk("R6 next cycle", int'(gnt_s[0 +: NS]), 2);
    // R2: written entry loses to every other
    req_s[0 +: NS] = 6'b000011;
    #1;
    chk("R2 new entry youngest", int'(gnt_s[0 +: NS]), 2);
    clear_reqs();

    // R3: port 0 older than port 1 in the same cycle
    no_enq();
    p0[1] = 3; p1[1] = 1;
    do_cycle();
    req_s[0 +: NS] = 6'b001010;
    #1;
    chk("R3 port0 older", int'(gnt_s[0 +: NS]), 8);
    clear_reqs();

    // random writes, exhaustive sweeps
    for (int r = 0; r < 150; r++) begin
      for (int g = 0; g < 3; g++) begin
        p0[g] = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, sz[g] - 1));
        p1[g] = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, sz[g] - 1));
        if (p1[g] == p0[g]) p1[g] = -1;
      end
      do_cycle();
      for (int g = 0; g < 3; g++) sweep(g);
      for (int k = 0; k < 6; k++) begin
        int me = (k == 0) ? 0 : int'($urandom_range(0, 3));
        int ms = (k < 2) ? 0 : int'($urandom_range(0, 63));
        int mc = (k < 4) ? 0 : int'($urandom_range(0, 15));
        comb_check(me, ms, mc);
      end
    end
    comb_check(0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule